// File: doc/BRIEF.md
# Synchronous-Group PWM Generator with Locked Buffered Update

This block drives several pulse-width channels, each with a complementary output pair separated by a programmable dead time. A mask register chooses which channels join a synchronous group. Every member of the group runs from the counter and period of channel 0. The group starts and stops with channel 0's enable bit alone. Channels outside the group run on their own counters with their own enable bits.

Period, duty and dead-time values are double-buffered. Software writes new values into per-channel update registers. For group members these reach the active registers only in the manual update mode, after software arms an unlock bit, and only at the next period boundary of the group. All members transfer together in one cycle. Then the unlock bit clears itself. Software watches the bit to know when it may stage the next set of values.

The update path is a small state machine with two states. In `UPD_LOCKED`, a write of 1 to the unlock bit while the mode field is 0 takes the transition *arm* into `UPD_ARMED`. In `UPD_ARMED`, a group boundary takes the transition *transfer*: all members load their active registers and the machine returns to `UPD_LOCKED`. In `UPD_ARMED`, an unlock write takes no transition.

Top module: `sync_pwm_group`

## Requirements
- R1: After reset, every register reads 0, the unlock bit reads 0, and both outputs of every channel are low.
- R2: The register map is as follows. Address 0x00 holds the mode register: the group mask in bits [NCH-1:0] and the update mode in bits [9:8]. Address 0x01 holds one enable bit per channel. Bit 0 of address 0x02 is the unlock bit. The update registers of channel c sit at 0x10+4c, 0x11+4c and 0x12+4c (period, duty, dead time) and read back as written. The active registers read at 0x40+4c, 0x41+4c and 0x42+4c.
- R3: A channel is a group member when its mask bit is 1. Channel 0 is always a member. Members count with channel 0's counter, so their waveform repeats with channel 0's active period.
- R4: All members run when channel 0's enable bit is 1 and stop when it is 0. The members' own enable bits have no effect on them.
- R5: In update mode 0, writing 1 to the unlock bit arms an update. The bit then reads 1 until the transfer takes place and reads 0 from then on.
- R6: An armed update moves period, duty and dead time from the update registers into the active registers of every member at the next group boundary. A group boundary is the last count of channel 0 while it runs, and with active period 0 every cycle is a boundary.
- R7: While no update is armed, the active registers of members do not change, even across period boundaries.
- R8: Update registers written while an update is armed keep only their latest value, and that value is the one transferred. A write in the boundary cycle itself lands after the transfer.
- R9: When the update mode field is not 0, writes to the unlock bit are ignored and the bit stays 0.
- R10: A non-member channel runs on its own enable bit and counter. It copies its update registers to its active registers at each of its own period boundaries, and continuously while it is stopped, with no unlock needed.
- R11: A channel's counter runs from 0 to period−1 and wraps. The raw pulse is high while the counter is below the active duty value, so it lasts duty cycles in each period.
- R12: The high output rises dead-time cycles after the raw pulse rises. The low output rises dead-time cycles after the raw pulse falls. Both outputs are low while the channel is stopped, and they are never high together. Each period therefore gives duty−dt high cycles and period−duty−dt low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address for write and read |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr`, combinational |
| pwm_hi | output | NCH | High-side output per channel |
| pwm_lo | output | NCH | Complementary low-side output per channel |

## Verification
Two events can fall in the same cycle: the unlock write and the group boundary. The bench makes them coincide by setting channel 0's active period to 0, so that every cycle is a boundary. It then checks that the unlock bit reads 1 right after the write, that the active registers are still old at that point, and that one clock later the transfer has happened for both members and the bit reads 0. The second meeting of events is a staged write landing while an update is armed. The bench aligns with the start of a period by watching the low output fall, writes twice, and checks that the second value is the one transferred.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    typedef enum logic [0:0] {
        UPD_LOCKED = 1'b0,
        UPD_ARMED  = 1'b1
    } upd_state_e;

    localparam logic [7:0] A_MODE     = 8'h00;
    localparam logic [7:0] A_ENA      = 8'h01;
    localparam logic [7:0] A_UCTL     = 8'h02;
    localparam logic [7:0] A_UPD_BASE = 8'h10;
    localparam logic [7:0] A_ACT_BASE = 8'h40;
    localparam int         CH_STRIDE  = 4;
    localparam int         MODE_LSB   = 8;
    localparam int         MODE_W     = 2;

endpackage

// File: rtl/spwm_upd_fsm.sv
module spwm_upd_fsm
    import spwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic grp_bnd,
    output logic armed,
    output logic xfer
);

    upd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_LOCKED: if (arm_req) state_d = UPD_ARMED;
            UPD_ARMED:  if (grp_bnd) state_d = UPD_LOCKED;
        endcase
    end

    always_comb begin
        armed = (state_q == UPD_ARMED);
        xfer  = (state_q == UPD_ARMED) && grp_bnd;
    end

    // R5: a transfer drops the unlock bit on the next cycle
    p_unlock_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !armed);

    // R5: a request while locked arms
    p_unlock_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && arm_req) |=> armed);

endmodule

// File: rtl/spwm_deadtime.sv
module spwm_deadtime #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          raw,
    input  logic [CW-1:0] dt,
    output logic          hi,
    output logic          lo
);

    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    logic          raw_d;
    logic [CW-1:0] el_q, el_now;
    logic          chg;

    always_comb begin
        chg    = (raw != raw_d);
        el_now = chg ? '0 : ((el_q == SAT) ? el_q : el_q + 1'b1);
        hi     = run &&  raw && (el_now >= dt);
        lo     = run && !raw && (el_now >= dt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_d <= 1'b0;
            el_q  <= SAT;
        end else begin
            raw_d <= raw;
            el_q  <= el_now;
        end
    end

    // R12: complementary outputs never overlap
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));

endmodule

// File: rtl/spwm_chan.sv
module spwm_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          use_ext,
    input  logic [CW-1:0] ext_cnt,
    input  logic          load,
    input  logic [CW-1:0] upd_per,
    input  logic [CW-1:0] upd_duty,
    input  logic [CW-1:0] upd_dt,
    output logic [CW-1:0] act_per,
    output logic [CW-1:0] act_duty,
    output logic [CW-1:0] act_dt,
    output logic [CW-1:0] cnt,
    output logic          bnd,
    output logic          raw
);

    logic [CW-1:0] cnt_q, cnt_eff;
    logic          wrap;

    always_comb begin
        wrap    = (act_per == '0) || (cnt_q >= act_per - 1'b1);
        bnd     = run && !use_ext && wrap;
        cnt_eff = use_ext ? ext_cnt : cnt_q;
        cnt     = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            raw      <= 1'b0;
            act_per  <= '0;
            act_duty <= '0;
            act_dt   <= '0;
        end else begin
            if (!run || use_ext || wrap) cnt_q <= '0;
            else                         cnt_q <= cnt_q + 1'b1;
            raw <= run && (cnt_eff < act_duty);
            if (load) begin
                act_per  <= upd_per;
                act_duty <= upd_duty;
                act_dt   <= upd_dt;
            end
        end
    end

    // R11: the local counter stays inside the active period
    p_cnt_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !use_ext && act_per != '0) |-> (cnt_q < act_per));

endmodule

// File: rtl/sync_pwm_group.sv
module sync_pwm_group
    import spwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     addr,
    input  logic [CW-1:0]  wdata,
    output logic [CW-1:0]  rdata,
    output logic [NCH-1:0] pwm_hi,
    output logic [NCH-1:0] pwm_lo
);

    logic [NCH-1:0]    mask_q, ena_q, member, run, load, bnd, raw;
    logic [MODE_W-1:0] umode_q;
    logic [CW-1:0]     upd_per [NCH];
    logic [CW-1:0]     upd_duty[NCH];
    logic [CW-1:0]     upd_dt  [NCH];
    logic [CW-1:0]     act_per [NCH];
    logic [CW-1:0]     act_duty[NCH];
    logic [CW-1:0]     act_dt  [NCH];
    logic [CW-1:0]     cnt     [NCH];
    logic              arm_req, armed, xfer;

    assign arm_req = wr_en && (addr == A_UCTL) && wdata[0] && (umode_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            umode_q <= '0;
            ena_q   <= '0;
        end else if (wr_en) begin
            if (addr == A_MODE) begin
                mask_q  <= wdata[NCH-1:0];
                umode_q <= wdata[MODE_LSB +: MODE_W];
            end
            if (addr == A_ENA) ena_q <= wdata[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                upd_per[c]  <= '0;
                upd_duty[c] <= '0;
                upd_dt[c]   <= '0;
            end
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == A_UPD_BASE + 8'(CH_STRIDE * c))      upd_per[c]  <= wdata;
                if (addr == A_UPD_BASE + 8'(CH_STRIDE * c + 1))  upd_duty[c] <= wdata;
                if (addr == A_UPD_BASE + 8'(CH_STRIDE * c + 2))  upd_dt[c]   <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MODE) begin
            rdata[NCH-1:0]            = mask_q;
            rdata[MODE_LSB +: MODE_W] = umode_q;
        end
        if (addr == A_ENA)  rdata[NCH-1:0] = ena_q;
        if (addr == A_UCTL) rdata[0] = armed;
        for (int c = 0; c < NCH; c++) begin
            if (addr == A_UPD_BASE + 8'(CH_STRIDE * c))     rdata = upd_per[c];
            if (addr == A_UPD_BASE + 8'(CH_STRIDE * c + 1)) rdata = upd_duty[c];
            if (addr == A_UPD_BASE + 8'(CH_STRIDE * c + 2)) rdata = upd_dt[c];
            if (addr == A_ACT_BASE + 8'(CH_STRIDE * c))     rdata = act_per[c];
            if (addr == A_ACT_BASE + 8'(CH_STRIDE * c + 1)) rdata = act_duty[c];
            if (addr == A_ACT_BASE + 8'(CH_STRIDE * c + 2)) rdata = act_dt[c];
        end
    end

    spwm_upd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (arm_req),
        .grp_bnd (bnd[0]),
        .armed   (armed),
        .xfer    (xfer)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign member[i] = (i == 0) || mask_q[i];
        assign run[i]    = member[i] ? ena_q[0] : ena_q[i];
        assign load[i]   = member[i] ? xfer : (!run[i] || bnd[i]);

        spwm_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[i]),
            .use_ext  (member[i] && (i != 0)),
            .ext_cnt  (cnt[0]),
            .load     (load[i]),
            .upd_per  (upd_per[i]),
            .upd_duty (upd_duty[i]),
            .upd_dt   (upd_dt[i]),
            .act_per  (act_per[i]),
            .act_duty (act_duty[i]),
            .act_dt   (act_dt[i]),
            .cnt      (cnt[i]),
            .bnd      (bnd[i]),
            .raw      (raw[i])
        );

        spwm_deadtime #(.CW(CW)) u_dt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run[i]),
            .raw   (raw[i]),
            .dt    (act_dt[i]),
            .hi    (pwm_hi[i]),
            .lo    (pwm_lo[i])
        );

        // R7: members keep their active duty while nothing is armed
        p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed && member[i]) |=> $stable(act_duty[i]));
    end

    // R9: unlock writes in a non-manual mode leave the update locked
    p_mode_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_UCTL && umode_q != '0 && !armed) |=> !armed);

endmodule

// File: tb/test_sync_pwm_group.sv
module test_sync_pwm_group;

    localparam int NCH = 4;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     addr = '0;
    logic [CW-1:0]  wdata = '0;
    logic [CW-1:0]  rdata;
    logic [NCH-1:0] pwm_hi, pwm_lo;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sync_pwm_group #(.NCH(NCH), .CW(CW)) i_sync_pwm_group (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    function automatic logic [7:0] a_upd(int c, int k);
        return 8'(8'h10 + 4 * c + k);
    endfunction
    function automatic logic [7:0] a_act(int c, int k);
        return 8'(8'h40 + 4 * c + k);
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic measure(int ch, int n, output int h, output int l, output int ov);
        h = 0; l = 0; ov = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_hi[ch]) h++;
            if (pwm_lo[ch]) l++;
            if (pwm_hi[ch] && pwm_lo[ch]) ov++;
        end
    endtask

    task automatic wait_unlocked(output int left);
        int v;
        left = 300;
        rd(8'h02, v);
        while (v[0] && left > 0) begin
            @(negedge clk);
            rd(8'h02, v);
            left--;
        end
    endtask

    task automatic t_reset;
        int v;
        @(negedge clk);
        check("R1", int'(pwm_hi), 0, "hi outputs after reset");
        check("R1", int'(pwm_lo), 0, "lo outputs after reset");
        rd(8'h00, v); check("R1", v, 0, "mode register");
        rd(8'h02, v); check("R1", v, 0, "unlock bit");
        rd(a_act(0, 1), v); check("R1", v, 0, "active duty ch0");
    endtask

    // unlock write coinciding with a boundary (period 0)
    task automatic t_coincide;
        int v;
        wr(8'h00, 3);
        wr(8'h01, 1);
        wr(a_upd(0, 0), 40); wr(a_upd(0, 1), 20); wr(a_upd(0, 2), 3);
        wr(a_upd(1, 0), 99); wr(a_upd(1, 1), 10); wr(a_upd(1, 2), 2);
        rd(a_upd(1, 1), v); check("R2", v, 10, "update duty readback ch1");
        repeat (5) @(negedge clk);
        rd(a_act(0, 1), v); check("R7", v, 0, "ch0 duty locked across boundaries");
        wr(8'h02, 1);
        rd(8'h02, v); check("R5", v, 1, "unlock reads 1 after write");
        rd(a_act(1, 1), v); check("R6", v, 0, "ch1 duty not yet moved");
        @(negedge clk);
        rd(8'h02, v); check("R5", v, 0, "unlock clears after transfer");
        rd(a_act(0, 0), v); check("R6", v, 40, "ch0 period moved");
        rd(a_act(0, 1), v); check("R6", v, 20, "ch0 duty moved");
        rd(a_act(0, 2), v); check("R6", v, 3, "ch0 dead time moved");
        rd(a_act(1, 0), v); check("R6", v, 99, "ch1 period moved");
        rd(a_act(1, 1), v); check("R6", v, 10, "ch1 duty moved");
        rd(a_act(1, 2), v); check("R6", v, 2, "ch1 dead time moved");
    endtask

    task automatic t_waves;
        int h, l, ov;
        repeat (90) @(negedge clk);
        measure(0, 120, h, l, ov);
        check("R11", h, 51, "ch0 high cycles over 3 periods");
        check("R12", l, 51, "ch0 low cycles over 3 periods");
        check("R12", ov, 0, "ch0 overlap");
        measure(1, 120, h, l, ov);
        check("R3", h, 24, "ch1 high cycles on ch0 period");
        check("R3", l, 84, "ch1 low cycles on ch0 period");
        check("R12", ov, 0, "ch1 overlap");
    endtask

    task automatic t_group_start;
        int h, l, ov;
        wr(8'h01, 2);
        repeat (3) @(negedge clk);
        measure(1, 50, h, l, ov);
        check("R4", h + l, 0, "ch1 idle with ch0 disabled and own bit set");
        wr(8'h01, 1);
        repeat (90) @(negedge clk);
        measure(1, 40, h, l, ov);
        check("R4", h, 8, "ch1 runs from ch0 enable only");
    endtask

    task automatic t_lock;
        int v;
        wr(a_upd(0, 1), 30);
        repeat (100) @(negedge clk);
        rd(a_act(0, 1), v); check("R7", v, 20, "ch0 duty held while locked");
        rd(a_upd(0, 1), v); check("R2", v, 30, "staged duty readback");
    endtask

    task automatic t_overwrite;
        int v, left;
        while (!pwm_lo[0]) @(negedge clk);
        while (pwm_lo[0])  @(negedge clk);
        wr(8'h02, 1);
        wr(a_upd(0, 1), 25);
        rd(a_act(0, 1), v); check("R8", v, 20, "active unchanged before boundary");
        rd(8'h02, v); check("R5", v, 1, "unlock held while armed");
        wait_unlocked(left);
        check("R5", int'(left > 0), 1, "unlock cleared within a period");
        rd(a_act(0, 1), v); check("R8", v, 25, "last staged duty transferred");
    endtask

    task automatic t_mode;
        int v;
        wr(8'h00, (1 << 8) | 3);
        wr(a_upd(0, 1), 12);
        wr(8'h02, 1);
        rd(8'h02, v); check("R9", v, 0, "unlock ignored in mode 1");
        repeat (100) @(negedge clk);
        rd(a_act(0, 1), v); check("R9", v, 25, "no transfer in mode 1");
        wr(8'h00, 3);
    endtask

    task automatic t_nonmember;
        int v, h, l, ov;
        wr(a_upd(2, 0), 10); wr(a_upd(2, 1), 4); wr(a_upd(2, 2), 1);
        rd(a_act(2, 1), v); check("R10", v, 4, "stopped non-member loads freely");
        rd(a_act(2, 0), v); check("R10", v, 10, "stopped non-member period loaded");
        wr(8'h01, 5);
        repeat (25) @(negedge clk);
        measure(2, 30, h, l, ov);
        check("R10", h, 9, "ch2 high cycles on own period");
        check("R12", l, 15, "ch2 low cycles on own period");
        wr(a_upd(2, 1), 6);
        repeat (25) @(negedge clk);
        rd(a_act(2, 1), v); check("R10", v, 6, "running non-member loads at own boundary");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_coincide;
        t_waves;
        t_group_start;
        t_lock;
        t_overwrite;
        t_mode;
        t_nonmember;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule